// File: doc/BRIEF.md
# Next-PC and Link Selection Unit

This block owns the program counter of a single-cycle processor that completes one instruction per clock. Each cycle it looks at the current PC, the fetched instruction word, the first register operand and a zero-test result. Control strobes from the decoder tell it whether the instruction is a plain step, a conditional branch on zero, or an unconditional transfer. From these it forms the address of the next instruction, and the PC register takes that address on the rising clock edge.

The choice is made in two levels. The first level decides between the sequential address and a taken transfer. A transfer is taken when the jump strobe is set, or when the branch strobe is set and the zero test is true. The second level decides whether a taken transfer goes to a PC-relative target or to the register operand.

For call-style instructions the block also supplies the return address and the fixed link register number to write-back, together with a write strobe. This lets branch-on-zero, relative jump, relative jump-and-link, register jump and register jump-and-link be driven by one small set of controls.

Top module: `npc_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `pc` becomes 0 on that edge, whatever the other inputs are.
- R2: When `jump_en` and `branch_en` are both low, `pc` advances by 4 at the next rising edge.
- R3: When `branch_en` is high, `jump_en` is low and `zero_flag` is high, with `sel_indirect` low, the new `pc` is pc + 4 + sign-extended `instr[15:0]`; `instr[31:16]` has no effect.
- R4: When `branch_en` is high, `jump_en` is low and `zero_flag` is low, `pc` advances by 4 whatever `instr`, `rs1_val` and `sel_indirect` hold.
- R5: When `jump_en` is high and `sel_indirect` is low, the new `pc` is pc + 4 + sign-extended `instr[25:0]`, regardless of `branch_en` and `zero_flag`.
- R6: When a transfer is taken (R3 or R5 condition) and `sel_indirect` is high, the new `pc` equals `rs1_val`.
- R7: `link_val` always equals pc + 4. `link_we` is high exactly when both `link_en` and `jump_en` are high. `link_dest` is register number 31.
- R8: All PC arithmetic is 32-bit modulo 2^32; stepping from 0xFFFFFFFC gives 0, and negative offsets move the PC backwards.
- R9: `next_pc` shows, in the same cycle, the value that `pc` takes at the next edge when `rst` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| instr | input | 32 | Fetched instruction word |
| rs1_val | input | 32 | First register operand value |
| zero_flag | input | 1 | High when the tested register equals zero |
| jump_en | input | 1 | Unconditional transfer strobe |
| branch_en | input | 1 | Branch-on-zero strobe |
| sel_indirect | input | 1 | Second-level select: 1 = register target, 0 = PC-relative |
| link_en | input | 1 | Instruction saves a return address |
| pc | output | 32 | Current program counter |
| next_pc | output | 32 | Address loaded into pc at the next edge |
| link_val | output | 32 | Return address for write-back |
| link_dest | output | 5 | Destination register number for the link write |
| link_we | output | 1 | Link write strobe |

## Verification
The assertions take for granted that the control strobes are driven to known values on every cycle after reset. They also assume `sel_indirect` and `link_en` are only meaningful alongside the strobes described in the requirements. The bench stimulus respects this: it sets every strobe on every cycle, including the combinations where jump and branch are high together, and the combinations where indirect or link are set without a taken transfer. Offsets are chosen so that forward, backward and wrapping targets all occur while the PC stays on word boundaries.

// File: rtl/npc_pkg.sv
package npc_pkg;
  typedef enum logic {
    SRC_STEP  = 1'b0,
    SRC_TAKEN = 1'b1
  } src_lvl1_e;

  typedef enum logic {
    TGT_PCREL = 1'b0,
    TGT_REG   = 1'b1
  } src_lvl2_e;
endpackage

// File: rtl/npc_imm_ext.sv
module npc_imm_ext #(
  parameter int IN_W  = 16,
  parameter int OUT_W = 32
) (
  input  logic [IN_W-1:0]  field_i,
  output logic [OUT_W-1:0] value_o
);
  localparam int PAD_W = OUT_W - IN_W;

  generate
    if (PAD_W > 0) begin : g_pad
      assign value_o = {{PAD_W{field_i[IN_W-1]}}, field_i};
    end else begin : g_nopad
      assign value_o = field_i[OUT_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/npc_target_gen.sv
module npc_target_gen #(
  parameter int XLEN     = 32,
  parameter int INSTR_W  = 32,
  parameter int BR_IMM_W = 16,
  parameter int J_IMM_W  = 26,
  parameter int STEP     = 4
) (
  input  logic [XLEN-1:0]    pc_i,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic               long_off_i,
  output logic [XLEN-1:0]    step_o,
  output logic [XLEN-1:0]    rel_o
);
  localparam logic [XLEN-1:0] STEP_V = XLEN'(STEP);

  logic [XLEN-1:0] br_off;
  logic [XLEN-1:0] j_off;
  logic [XLEN-1:0] off_sel;

  npc_imm_ext #(.IN_W(BR_IMM_W), .OUT_W(XLEN)) u_br_ext (
    .field_i (instr_i[BR_IMM_W-1:0]),
    .value_o (br_off)
  );

  npc_imm_ext #(.IN_W(J_IMM_W), .OUT_W(XLEN)) u_j_ext (
    .field_i (instr_i[J_IMM_W-1:0]),
    .value_o (j_off)
  );

  always_comb begin
    off_sel = long_off_i ? j_off : br_off;
    step_o  = pc_i + STEP_V;
    rel_o   = step_o + off_sel;
  end
endmodule

// File: rtl/npc_sel.sv
module npc_sel
  import npc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            jump_i,
  input  logic            branch_i,
  input  logic            zero_i,
  input  logic            indirect_i,
  input  logic [XLEN-1:0] step_i,
  input  logic [XLEN-1:0] rel_i,
  input  logic [XLEN-1:0] reg_i,
  output logic [XLEN-1:0] next_o
);
  src_lvl1_e lvl1;
  src_lvl2_e lvl2;
  logic [XLEN-1:0] taken_tgt;

  always_comb begin
    lvl1 = (jump_i || (branch_i && zero_i)) ? SRC_TAKEN : SRC_STEP;
    lvl2 = indirect_i ? TGT_REG : TGT_PCREL;
    taken_tgt = (lvl2 == TGT_REG) ? reg_i : rel_i;
    next_o = (lvl1 == SRC_TAKEN) ? taken_tgt : step_i;
  end
endmodule

// File: rtl/npc_pc_reg.sv
module npc_pc_reg #(
  parameter int              XLEN     = 32,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [XLEN-1:0] d_i,
  output logic [XLEN-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (rst) q_o <= RESET_PC;
    else     q_o <= d_i;
  end
endmodule

// File: rtl/npc_unit.sv
module npc_unit #(
  parameter int XLEN     = 32,
  parameter int INSTR_W  = 32,
  parameter int BR_IMM_W = 16,
  parameter int J_IMM_W  = 26,
  parameter int STEP     = 4,
  parameter int REG_AW   = 5,
  parameter int LINK_REG = 31
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [INSTR_W-1:0] instr,
  input  logic [XLEN-1:0]    rs1_val,
  input  logic               zero_flag,
  input  logic               jump_en,
  input  logic               branch_en,
  input  logic               sel_indirect,
  input  logic               link_en,
  output logic [XLEN-1:0]    pc,
  output logic [XLEN-1:0]    next_pc,
  output logic [XLEN-1:0]    link_val,
  output logic [REG_AW-1:0]  link_dest,
  output logic               link_we
);
  localparam logic [XLEN-1:0]   RESET_PC = '0;
  localparam logic [REG_AW-1:0] LINK_ID  = REG_AW'(LINK_REG);
  localparam logic [XLEN-1:0]   STEP_V   = XLEN'(STEP);

  logic [XLEN-1:0] step_addr;
  logic [XLEN-1:0] rel_addr;

  npc_target_gen #(
    .XLEN(XLEN), .INSTR_W(INSTR_W), .BR_IMM_W(BR_IMM_W),
    .J_IMM_W(J_IMM_W), .STEP(STEP)
  ) u_tgt (
    .pc_i       (pc),
    .instr_i    (instr),
    .long_off_i (jump_en),
    .step_o     (step_addr),
    .rel_o      (rel_addr)
  );

  npc_sel #(.XLEN(XLEN)) u_sel (
    .jump_i     (jump_en),
    .branch_i   (branch_en),
    .zero_i     (zero_flag),
    .indirect_i (sel_indirect),
    .step_i     (step_addr),
    .rel_i      (rel_addr),
    .reg_i      (rs1_val),
    .next_o     (next_pc)
  );

  npc_pc_reg #(.XLEN(XLEN), .RESET_PC(RESET_PC)) u_pc (
    .clk (clk),
    .rst (rst),
    .d_i (next_pc),
    .q_o (pc)
  );

  assign link_val  = step_addr;
  assign link_dest = LINK_ID;
  assign link_we   = link_en & jump_en;

  // Assertions
  assert_reset_pc_R1: assert property (@(posedge clk)
    rst |=> (pc == RESET_PC));

  assert_step_R2: assert property (@(posedge clk) disable iff (rst)
    (!jump_en && !branch_en) |=> (pc == $past(pc) + STEP_V));

  assert_fallthru_R4: assert property (@(posedge clk) disable iff (rst)
    (branch_en && !jump_en && !zero_flag) |=> (pc == $past(pc) + STEP_V));

  assert_indirect_R6: assert property (@(posedge clk) disable iff (rst)
    (jump_en && sel_indirect) |=> (pc == $past(rs1_val)));

  assert_link_gate_R7: assert property (@(posedge clk) disable iff (rst)
    link_we |-> jump_en);

  assert_preview_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (pc == $past(next_pc)));
endmodule

// File: tb/npc_unit_tb_top.sv
module npc_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] instr, rs1_val;
  logic        zero_flag, jump_en, branch_en, sel_indirect, link_en;
  logic [31:0] pc, next_pc, link_val;
  logic [4:0]  link_dest;
  logic        link_we;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  npc_unit dut_i (
    .clk(clk), .rst(rst), .instr(instr), .rs1_val(rs1_val),
    .zero_flag(zero_flag), .jump_en(jump_en), .branch_en(branch_en),
    .sel_indirect(sel_indirect), .link_en(link_en),
    .pc(pc), .next_pc(next_pc), .link_val(link_val),
    .link_dest(link_dest), .link_we(link_we)
  );

  typedef struct packed {
    logic [31:0] ins;
    logic [31:0] rs;
    logic        zf, jp, br, ind, lk;
    logic [31:0] exp_pc;
    logic [31:0] exp_lv;
    logic        exp_we;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t TBL [NV] = '{
    '{32'h0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h4,        32'h4,        1'b0},
    '{32'hFFFF_FFFF, 32'h123, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 32'h8, 32'h8,    1'b0},
    '{32'h0000_0010, 32'h0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 32'h1C,       32'hC,        1'b0},
    '{32'h0000_0010, 32'h999, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 32'h20,     32'h20,       1'b0},
    '{32'h0000_FFF0, 32'h0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 32'h14,       32'h24,       1'b0},
    '{32'h0000_0100, 32'h0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h118,      32'h18,       1'b0},
    '{32'h03FF_FFF0, 32'h0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 32'h10C,      32'h11C,      1'b1},
    '{32'h0, 32'h0000_4000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 32'h4000,     32'h110,      1'b0},
    '{32'h0, 32'hFFFF_FFFC, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 32'hFFFF_FFFC, 32'h4004,    1'b1},
    '{32'h0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0,                32'h0,        1'b0},
    '{32'h0000_0040, 32'h0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 32'h44,       32'h4,        1'b0},
    '{32'hFFFF_0008, 32'h0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 32'h50,       32'h48,       1'b0},
    '{32'h0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 32'h54,               32'h54,       1'b0}
  };

  task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    instr = v.ins; rs1_val = v.rs; zero_flag = v.zf; jump_en = v.jp;
    branch_en = v.br; sel_indirect = v.ind; link_en = v.lk;
  endtask

  initial begin : watchdog
    repeat (2000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1;
    drive(TBL[0]);
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    check32("R1 reset pc", pc, 32'h0);
    rst = 1'b0;
    // Table walk: R2 step, R3 taken branch (upper bits ignored), R4 fall-through,
    // R5 relative jump priority, R6 register target, R7 link, R8 wrap, R9 preview
    for (int i = 0; i < NV; i++) begin
      drive(TBL[i]);
      #1;
      check32("R7 link_val", link_val, TBL[i].exp_lv);
      check32("R7 link_we", {31'b0, link_we}, {31'b0, TBL[i].exp_we});
      check32("R9 next_pc", next_pc, TBL[i].exp_pc);
      @(negedge clk);
      check32($sformatf("R2-R8 vector %0d pc", i), pc, TBL[i].exp_pc);
    end
    check32("R7 link_dest", {27'b0, link_dest}, 32'd31);
    // R1: reset wins over a pending jump
    drive('{32'h0, 32'hABCD_0000, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 32'h0, 32'h0, 1'b0});
    rst = 1'b1;
    @(negedge clk);
    check32("R1 reset over jump", pc, 32'h0);
    rst = 1'b0;
    // R6: taken branch with register target
    drive('{32'h0000_0100, 32'h0000_0800, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 32'h0, 32'h0, 1'b0});
    @(negedge clk);
    check32("R6 branch to register", pc, 32'h800);
    // R8: relative jump wraps past the top of the address space
    drive('{32'h0, 32'hFFFF_FFF8, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 32'h0, 32'h0, 1'b0});
    @(negedge clk);
    drive('{32'h0000_0010, 32'h0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0, 1'b0});
    @(negedge clk);
    check32("R8 relative wrap", pc, 32'h0000_000C);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule